// File: doc/BRIEF.md
# Calibrated Two-Point ADC Code to Millivolt Converter

This block turns a raw 12-bit converter code into a voltage in millivolts by linear interpolation between two known points. There are two interpolation lines. The wide-range line is used for the battery-sense channel, and the narrow-range line is used for every other channel. Each line has two fixed voltage anchors. Its two code anchors are not fixed: they are trimmed from a nominal value by a 16-bit calibration word. The calibration words arrive on input ports and are sampled together with each request. If the interpolated voltage is below zero, it is clamped to zero.

Two channels are already calibrated on-die. For those, the interpolated value is the answer. All other channels sit behind a resistor divider. For those, the interpolated value is multiplied by the divider's denominator and then divided by its numerator, rounding to the nearest integer. Both divisions run on one shared restoring divider that produces one quotient bit per clock.

A request is a one-cycle `start` pulse with the code, channel, ratio and calibration words valid in that cycle. The result appears on `volt_mv` together with a one-cycle `done` pulse, and it holds until the next result. A divisor that would be zero does not hang the block: it yields 0 with `err` set.

The controller states are:
- IDLE: waits for `start`.
- SETUP: forms the signed product and the code span, or goes straight to FINISH when the span is zero.
- SPAN_DIV: waits for the interpolation quotient, then goes to FINISH or to RATIO_DIV.
- RATIO_DIV: waits for the rounded ratio quotient.
- FINISH: raises `done`, then returns to IDLE.

Top module: `adc_volt_conv`

## Requirements
- R1: Channel 5 uses the wide-range line: 4200 mV at code point 0, 3600 mV at code point 1, nominal codes 856 and 733, trimmed by `cal_big`. Every other channel uses the narrow-range line: 1000 mV and 100 mV, nominal codes 833 and 80, trimmed by `cal_small`.
- R2: Each code point is (trim byte + nominal − 128) × 4, with the trim byte read as unsigned. Bits [7:0] of the calibration word trim point 0, and bits [15:8] trim point 1.
- R3: The interpolated voltage is v1 + ((v0 − v1)·(raw − c1)) / (c0 − c1). The division is signed and truncates toward zero, and it works for either sign of the span.
- R4: A negative interpolated voltage becomes 0 before any further step.
- R5: Channels 5 and 1 output the clamped interpolated voltage directly, and `ratio` is ignored for them.
- R6: Every other channel outputs (volt·den + num/2) / num, where num = `ratio[31:16]` and den = `ratio[15:0]`.
- R7: When c0 equals c1, the result is 0 with `err`=1.
- R8: A zero numerator on a ratio channel gives 0 with `err`=1. On channels 5 and 1 a zero numerator gives a normal result with `err`=0.
- R9: `done` is high for exactly one cycle per accepted request. After the edge that samples `start`, it rises after 1 edge (zero span), after DIV_W+2 edges (direct channel or zero numerator), or after 2·DIV_W+3 edges (ratio channel). DIV_W is 48 by default.
- R10: `start` is ignored while `busy` is high. The pending result is unaffected and no extra `done` occurs.
- R11: After reset, `volt_mv`=0, `err`=0, `done`=0 and `busy`=0. `volt_mv` and `err` change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| raw_code | input | 12 | Raw converter code |
| chan | input | 5 | Channel number |
| ratio | input | 32 | Divider ratio: numerator [31:16], denominator [15:0] |
| cal_big | input | 16 | Calibration word, wide-range line |
| cal_small | input | 16 | Calibration word, narrow-range line |
| volt_mv | output | 32 | Result in millivolts |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Zero-divisor flag, valid with `done` |
| busy | output | 1 | A request is in progress |

## Verification
Each request has one of three fixed latencies, counted from the edge that samples `start`:
- 1 edge when the span is zero.
- DIV_W+2 edges on a direct channel or a zero-numerator ratio channel.
- 2·DIV_W+3 edges on a ratio channel.

The driver stamps each queued expectation with the cycle of the sampling edge. The monitor compares the measured distance to the expected latency whenever `done` is seen, and it checks value and flag in that same cycle. A `done` with no queued item counts as a failure, so a second pulse or a restart while busy is caught.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SPAN_DIV,
        ST_RATIO_DIV,
        ST_FINISH
    } conv_state_e;

    localparam int N_GRAPHS = 2;
    localparam int GR_SMALL = 0;
    localparam int GR_BIG   = 1;

    // anchor voltage in mV of line g, point p
    function automatic int graph_volt(input int g, input int p);
        if (g == GR_BIG) return (p == 0) ? 4200 : 3600;
        else             return (p == 0) ? 1000 : 100;
    endfunction

    // untrimmed code of line g, point p
    function automatic int graph_nom(input int g, input int p);
        if (g == GR_BIG) return (p == 0) ? 856 : 733;
        else             return (p == 0) ? 833 : 80;
    endfunction

endpackage

// File: rtl/adc_cal_trim.sv
module adc_cal_trim #(
    parameter int PT_W = 16,
    parameter int NOM0 = 833,
    parameter int NOM1 = 80
) (
    input  logic [15:0]            cal_i,
    output logic signed [PT_W-1:0] pt0_o,
    output logic signed [PT_W-1:0] pt1_o
);
    localparam int BYTE_BIAS = 128;
    localparam int CODE_MUL  = 4;

    assign pt0_o = PT_W'((int'({1'b0, cal_i[7:0]})  + NOM0 - BYTE_BIAS) * CODE_MUL);
    assign pt1_o = PT_W'((int'({1'b0, cal_i[15:8]}) + NOM1 - BYTE_BIAS) * CODE_MUL);
endmodule

// File: rtl/adc_restoring_div.sv
module adc_restoring_div #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, valid_q;
    logic [W:0]       shifted, trial;
    logic [W-1:0]     rem_n, quo_n;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dsr_q};
        if (!trial[W]) begin
            rem_n = trial[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_n = shifted[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (go) begin
            rem_q   <= '0;
            quo_q   <= dividend;
            dsr_q   <= divisor;
            cnt_q   <= CNT_W'(W);
            run_q   <= 1'b1;
            valid_q <= 1'b0;
        end else if (run_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                run_q   <= 1'b0;
                valid_q <= 1'b1;
            end
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign quotient = quo_q;
    assign valid    = valid_q;
endmodule

// File: rtl/adc_volt_conv.sv
module adc_volt_conv
    import adc_conv_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int CHAN_W    = 5,
    parameter int OUT_W     = 32,
    parameter int RATIO_W   = 16,
    parameter int PT_W      = 16,
    parameter int ACC_W     = 32,
    parameter int BIG_CH    = 5,
    parameter int SMALL_CH  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CODE_W-1:0]    raw_code,
    input  logic [CHAN_W-1:0]    chan,
    input  logic [2*RATIO_W-1:0] ratio,
    input  logic [15:0]          cal_big,
    input  logic [15:0]          cal_small,
    output logic [OUT_W-1:0]     volt_mv,
    output logic                 done,
    output logic                 err,
    output logic                 busy
);
    localparam int DIV_W = OUT_W + RATIO_W;

    // ---------------- calibration trim, one per line ----------------
    logic [15:0]            cal_vec [N_GRAPHS];
    logic signed [PT_W-1:0] pt0_g   [N_GRAPHS];
    logic signed [PT_W-1:0] pt1_g   [N_GRAPHS];

    assign cal_vec[GR_SMALL] = cal_small;
    assign cal_vec[GR_BIG]   = cal_big;

    for (genvar g = 0; g < N_GRAPHS; g++) begin : g_trim
        adc_cal_trim #(
            .PT_W (PT_W),
            .NOM0 (graph_nom(g, 0)),
            .NOM1 (graph_nom(g, 1))
        ) u_trim (
            .cal_i (cal_vec[g]),
            .pt0_o (pt0_g[g]),
            .pt1_o (pt1_g[g])
        );
    end

    // ---------------- request registers ----------------
    conv_state_e             state_q, state_d;
    logic [CODE_W-1:0]       raw_q;
    logic                    direct_q;
    logic [RATIO_W-1:0]      rnum_q, rden_q;
    logic signed [PT_W-1:0]  c0_q, c1_q;
    logic signed [ACC_W-1:0] v0_q, v1_q;
    logic                    neg_q;
    logic [OUT_W-1:0]        volt_q;
    logic                    err_q;

    logic                    big_sel;
    assign big_sel = (chan == CHAN_W'(BIG_CH));

    // ---------------- shared divider ----------------
    logic             div_go, div_valid;
    logic [DIV_W-1:0] div_dividend, div_divisor, div_quot;

    adc_restoring_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quotient (div_quot),
        .valid    (div_valid)
    );

    // ---------------- arithmetic ----------------
    logic signed [ACC_W-1:0] span_s, off_s, prod_s, qmag_s, q_s, interp_s;
    logic [ACC_W-1:0]        prod_mag, span_mag, interp_u;
    logic [DIV_W-1:0]        scaled;
    logic                    span_zero, ratio_zero;

    always_comb begin
        span_s     = ACC_W'(c0_q) - ACC_W'(c1_q);
        off_s      = ACC_W'($signed({1'b0, raw_q})) - ACC_W'(c1_q);
        prod_s     = (v0_q - v1_q) * off_s;
        prod_mag   = prod_s[ACC_W-1] ? ACC_W'(-prod_s) : ACC_W'(prod_s);
        span_mag   = span_s[ACC_W-1] ? ACC_W'(-span_s) : ACC_W'(span_s);
        span_zero  = (span_s == '0);
        ratio_zero = (rnum_q == '0);
        qmag_s     = $signed(ACC_W'(div_quot));
        q_s        = neg_q ? -qmag_s : qmag_s;
        interp_s   = q_s + v1_q;
        interp_u   = interp_s[ACC_W-1] ? '0 : ACC_W'(interp_s);
        scaled     = DIV_W'(interp_u) * DIV_W'(rden_q) + DIV_W'(rnum_q >> 1);
    end

    always_comb begin
        div_go       = 1'b0;
        div_dividend = DIV_W'(prod_mag);
        div_divisor  = DIV_W'(span_mag);
        if (state_q == ST_SETUP && !span_zero) begin
            div_go = 1'b1;
        end else if (state_q == ST_SPAN_DIV && div_valid && !direct_q && !ratio_zero) begin
            div_go       = 1'b1;
            div_dividend = scaled;
            div_divisor  = DIV_W'(rnum_q);
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_SETUP;
            ST_SETUP:     state_d = span_zero ? ST_FINISH : ST_SPAN_DIV;
            ST_SPAN_DIV:  if (div_valid)
                              state_d = (direct_q || ratio_zero) ? ST_FINISH : ST_RATIO_DIV;
            ST_RATIO_DIV: if (div_valid) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q    <= '0;
            direct_q <= 1'b0;
            rnum_q   <= '0;
            rden_q   <= '0;
            c0_q     <= '0;
            c1_q     <= '0;
            v0_q     <= '0;
            v1_q     <= '0;
            neg_q    <= 1'b0;
            volt_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    raw_q    <= raw_code;
                    direct_q <= big_sel || (chan == CHAN_W'(SMALL_CH));
                    rnum_q   <= ratio[2*RATIO_W-1:RATIO_W];
                    rden_q   <= ratio[RATIO_W-1:0];
                    c0_q     <= big_sel ? pt0_g[GR_BIG] : pt0_g[GR_SMALL];
                    c1_q     <= big_sel ? pt1_g[GR_BIG] : pt1_g[GR_SMALL];
                    v0_q     <= ACC_W'(big_sel ? graph_volt(GR_BIG, 0) : graph_volt(GR_SMALL, 0));
                    v1_q     <= ACC_W'(big_sel ? graph_volt(GR_BIG, 1) : graph_volt(GR_SMALL, 1));
                end
                ST_SETUP: begin
                    neg_q <= prod_s[ACC_W-1] ^ span_s[ACC_W-1];
                    if (span_zero) begin
                        volt_q <= '0;
                        err_q  <= 1'b1;
                    end
                end
                ST_SPAN_DIV: if (div_valid) begin
                    if (direct_q) begin
                        volt_q <= OUT_W'(interp_u);
                        err_q  <= 1'b0;
                    end else if (ratio_zero) begin
                        volt_q <= '0;
                        err_q  <= 1'b1;
                    end
                end
                ST_RATIO_DIV: if (div_valid) begin
                    volt_q <= OUT_W'(div_quot);
                    err_q  <= 1'b0;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign volt_mv = volt_q;
    assign err     = err_q;
    assign done    = (state_q == ST_FINISH);
    assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_volt_conv_chk.sv
module adc_volt_conv_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OUT_W-1:0] volt_mv,
    input logic             done,
    input logic             err,
    input logic             busy
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done) || done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(volt_mv) && $stable(err)) || done);

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (volt_mv == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
endmodule

bind adc_volt_conv adc_volt_conv_chk #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .volt_mv (volt_mv),
    .done    (done),
    .err     (err),
    .busy    (busy)
);

// File: tb/tb_adc_volt_conv.sv
module tb_adc_volt_conv;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_STEPS  = 48;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [11:0] raw_code = '0;
    logic [4:0]  chan = '0;
    logic [31:0] ratio = '0;
    logic [15:0] cal_big = 16'h8080, cal_small = 16'h8080;
    logic [31:0] volt_mv;
    logic        done, err, busy;

    adc_volt_conv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_code(raw_code),
        .chan(chan), .ratio(ratio), .cal_big(cal_big), .cal_small(cal_small),
        .volt_mv(volt_mv), .done(done), .err(err), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] volt;
        logic        e;
        int          lat;
        int          t0;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // independent reference of the conversion rules
    task automatic ref_model(input logic [11:0] raw, input logic [4:0] ch, input logic [31:0] rt,
                             input logic [15:0] cb, input logic [15:0] cs,
                             output logic [31:0] v, output logic e, output int lat);
        longint v0, v1, n0, n1, c0, c1, t, rn, rd;
        logic [15:0] cw;
        if (ch == 5) begin v0 = 4200; v1 = 3600; n0 = 856; n1 = 733; cw = cb; end
        else         begin v0 = 1000; v1 = 100;  n0 = 833; n1 = 80;  cw = cs; end
        c0 = (longint'(cw[7:0])  + n0 - 128) * 4;
        c1 = (longint'(cw[15:8]) + n1 - 128) * 4;
        if (c0 == c1) begin v = 0; e = 1'b1; lat = 1; return; end
        t = ((v0 - v1) * (longint'(raw) - c1)) / (c0 - c1) + v1;
        if (t < 0) t = 0;
        if (ch == 5 || ch == 1) begin v = 32'(t); e = 1'b0; lat = DIV_STEPS + 2; return; end
        rn = longint'(rt[31:16]);
        rd = longint'(rt[15:0]);
        if (rn == 0) begin v = 0; e = 1'b1; lat = DIV_STEPS + 2; return; end
        v = 32'((t * rd + rn / 2) / rn);
        e = 1'b0;
        lat = 2 * DIV_STEPS + 3;
    endtask

    // monitor: pops one expectation per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(volt_mv == it.volt, {it.tag, " volt"}, volt_mv, it.volt);
                check(err == it.e, {it.tag, " err"}, err, it.e);
                check((cyc - it.t0) == it.lat, {"R9 latency ", it.tag}, cyc - it.t0, it.lat);
            end
        end
    end

    task automatic run_conv(input logic [11:0] raw, input logic [4:0] ch, input logic [31:0] rt,
                            input logic [15:0] cb, input logic [15:0] cs,
                            input string tag, input bit disturb);
        exp_t it;
        @(negedge clk);
        raw_code = raw; chan = ch; ratio = rt; cal_big = cb; cal_small = cs;
        ref_model(raw, ch, rt, cb, cs, it.volt, it.e, it.lat);
        it.t0  = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R10 busy after start ", tag}, busy, 1);
        if (disturb) begin
            repeat (5) @(negedge clk);
            raw_code = ~raw; chan = 5'd5; cal_big = 16'h7B00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check(volt_mv == 0, "R11 reset volt", volt_mv, 0);
        check(err == 0,     "R11 reset err",  err, 0);
        check(done == 0,    "R11 reset done", done, 0);
        check(busy == 0,    "R11 reset busy", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R5: wide-range line, direct channel
        run_conv(12'd3310, 5'd5, 32'h0, 16'h8080, 16'h0000, "R1 R5 big nominal", 1'b0);
        // R3: negative quotient truncates toward zero
        run_conv(12'd2900, 5'd5, 32'h0, 16'h8080, 16'h8080, "R3 trunc", 1'b0);
        // R2 R3: negative span (c0 < c1)
        run_conv(12'd3001, 5'd5, 32'h0, 16'hFF00, 16'h8080, "R2 R3 neg span", 1'b0);
        // R7: zero span on the wide line
        run_conv(12'd3000, 5'd5, 32'h0, 16'h7B00, 16'h8080, "R7 zero span", 1'b0);
        // R5: narrow-range direct channel
        run_conv(12'd2000, 5'd1, 32'h0, 16'h0000, 16'h8080, "R5 small direct", 1'b0);
        // R4: clamp to zero
        run_conv(12'd0, 5'd1, 32'h0, 16'h8080, 16'hFF80, "R4 clamp", 1'b0);
        // R2: byte mapping of the trim word
        run_conv(12'd1500, 5'd1, 32'h0, 16'h8080, 16'h10F0, "R2 trim bytes", 1'b0);
        // R6: ratio channels
        run_conv(12'd1200, 5'd14, {16'd68, 16'd900}, 16'h8080, 16'h8080, "R6 ratio a", 1'b0);
        run_conv(12'd3000, 5'd20, {16'd1, 16'd1}, 16'h8080, 16'h8080, "R6 unity", 1'b0);
        run_conv(12'd777, 5'd7, {16'd1000, 16'd1955}, 16'h8080, 16'h4A91, "R6 rounding", 1'b0);
        run_conv(12'd2500, 5'd22, {16'd3, 16'd8}, 16'h8080, 16'h8080, "R6 ratio b", 1'b0);
        // R4 on a ratio channel
        run_conv(12'd0, 5'd0, {16'd100, 16'd406}, 16'h8080, 16'hFF80, "R4 clamp ratio", 1'b0);
        // R8: zero numerator
        run_conv(12'd2222, 5'd9, {16'd0, 16'd125}, 16'h8080, 16'h8080, "R8 zero num", 1'b0);
        run_conv(12'd3400, 5'd5, {16'd0, 16'd0}, 16'h8080, 16'h8080, "R8 direct ignores num", 1'b0);
        // R10: start while busy is ignored
        run_conv(12'd1800, 5'd16, {16'd48, 16'd100}, 16'h8080, 16'h8080, "R10 start ignored", 1'b1);

        check(done == 0 && busy == 0, "R9 idle after runs", {done, busy}, 0);
        summary();
    end
endmodule